// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block writes one frame of raster lines into memory. Software programs a destination base address, a line pitch, a packed width and height and a control word through a small register port, then sets a self-clearing start bit. The block then takes a stream of 32-bit words that are already packed, each marked when it ends a line, and turns each word into one memory write request with its own address. Lines are laid out at the base address plus the line number times the pitch, and words within a line advance by four bytes.

While a frame is in flight a busy flag reads high, and a read-only counter shows how many lines have been committed. The frame ends when the count reaches the programmed height, or at once on an abort command. A power-down bit blocks the stream and any new start. An interrupt line is driven while the interrupt enable is set and the block is idle. Software acknowledges the interrupt by clearing the enable. A frame-start pulse marks each start and, when enabled, the end of each frame as well.

Top module: `wb_frame_writer`

## Requirements
- R1: Register word address 0 holds the destination base. Bits 1:0 of a write are dropped, so the base always reads back as a multiple of 4.
- R2: Register word address 1 holds the line pitch. A write with any of bits 3:0 set is rejected: the stored pitch keeps its old value and `pitch_err` goes high. A write with bits 3:0 clear stores the value and clears `pitch_err`.
- R3: Register word address 2 holds the width in bits 15:0 and the height in bits 31:16. A height above 4088 is stored and read back as 4088.
- R4: Control (word address 3) bit 0 starts a frame and always reads back as 0. A start is ignored while busy is set or while power-down is set.
- R5: Control bit 1 reads as busy. It goes high on an accepted start and low once the committed line count reaches the height.
- R6: Each accepted word yields, one cycle later, `mem_req` high with `mem_addr` = base + line*pitch + 4*word, `mem_data` equal to the word and `mem_strb` = 4'hf. No request is made otherwise.
- R7: Word address 4 reads the number of lines committed in the current frame. It counts end-of-line words and is cleared to 0 by each accepted start.
- R8: `irq` is high one cycle after control bit 2 (interrupt enable) is set while the block is idle. It goes low after software clears bit 2.
- R9: A control write with bit 14 (abort) set clears busy on that edge and suppresses all later writes of the frame. Bit 14 reads back as 0.
- R10: While control bit 21 (power-down) is set, `px_ready` is low and no memory request is issued.
- R11: Control bits 31:24 read as 8'h54 and bits 23:22 read as 2'b01.
- R12: `vstart` pulses for one cycle after an accepted start. It also pulses when a frame completes, if control bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, data valid next cycle |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pitch_err | output | 1 | Last pitch write was rejected |
| px_valid | input | 1 | Stream word valid |
| px_data | input | 32 | Packed pixel word |
| px_eol | input | 1 | Word ends a line |
| px_ready | output | 1 | Stream word accepted this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the write |
| mem_data | output | 32 | Write data |
| mem_strb | output | 4 | Byte strobes |
| vstart | output | 1 | Frame-start pulse |
| irq | output | 1 | Idle interrupt |

## Verification
Some rules are checked on every cycle: full byte strobes on every request, no request without a prior busy cycle, no request while powered down, busy low right after an abort, the progress counter at zero when busy rises, and the height cap. Other behaviour can only be shown by the bench's scenarios. This covers the address pattern across varied bases, pitches and line lengths, the end-of-frame pulse, rejected pitch writes, starts ignored while busy, and the raising and acknowledging of the interrupt.

// File: rtl/wbf_pkg.sv
package wbf_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_BASE  = 3'd0,
    RA_PITCH = 3'd1,
    RA_SIZE  = 3'd2,
    RA_CTRL  = 3'd3,
    RA_PROG  = 3'd4
  } reg_idx_e;

  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_BUSY  = 1;
  localparam int unsigned CB_IEN   = 2;
  localparam int unsigned CB_ABORT = 14;
  localparam int unsigned CB_VEOF  = 15;
  localparam int unsigned CB_PWRDN = 21;

  localparam logic [7:0] CTRL_TAG = 8'h54;
  localparam logic [1:0] CTRL_REV = 2'b01;
endpackage

// File: rtl/wbf_regs.sv
module wbf_regs
  import wbf_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DIM_W     = 16,
  parameter int unsigned MAX_LINES = 4088
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pitch_err,
  input  logic              busy,
  input  logic [DIM_W-1:0]  progress,
  output logic [AW-1:0]     base,
  output logic [AW-1:0]     pitch,
  output logic [DIM_W-1:0]  height,
  output logic              ien,
  output logic              veof,
  output logic              pwrdn,
  output logic              start_cmd,
  output logic              abort_cmd
);
  localparam logic [DIM_W-1:0] HCAP = DIM_W'(MAX_LINES);

  logic [DIM_W-1:0] width_q;
  logic [DIM_W-1:0] h_in;
  logic             ctrl_wr;
  logic [31:0]      ctrl_view;

  assign ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);
  assign abort_cmd = ctrl_wr && reg_wdata[CB_ABORT];
  assign start_cmd = ctrl_wr && reg_wdata[CB_START] && !reg_wdata[CB_ABORT]
                     && !reg_wdata[CB_PWRDN];
  assign h_in      = reg_wdata[2*DIM_W-1:DIM_W];

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[31:24]     = CTRL_TAG;
    ctrl_view[23:22]     = CTRL_REV;
    ctrl_view[CB_PWRDN]  = pwrdn;
    ctrl_view[CB_VEOF]   = veof;
    ctrl_view[CB_IEN]    = ien;
    ctrl_view[CB_BUSY]   = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      pitch     <= '0;
      width_q   <= '0;
      height    <= '0;
      ien       <= 1'b0;
      veof      <= 1'b0;
      pwrdn     <= 1'b0;
      pitch_err <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        unique case (reg_addr)
          RA_BASE:  base <= {reg_wdata[AW-1:2], 2'b00};
          RA_PITCH: begin
            if (reg_wdata[3:0] != 4'h0) begin
              pitch_err <= 1'b1;
            end else begin
              pitch     <= reg_wdata[AW-1:0];
              pitch_err <= 1'b0;
            end
          end
          RA_SIZE: begin
            width_q <= reg_wdata[DIM_W-1:0];
            height  <= (h_in > HCAP) ? HCAP : h_in;
          end
          RA_CTRL: begin
            ien   <= reg_wdata[CB_IEN];
            veof  <= reg_wdata[CB_VEOF];
            pwrdn <= reg_wdata[CB_PWRDN];
          end
          default: ;
        endcase
      end
      if (reg_rd) begin
        unique case (reg_addr)
          RA_BASE:  reg_rdata <= base;
          RA_PITCH: reg_rdata <= pitch;
          RA_SIZE:  reg_rdata <= {height, width_q};
          RA_CTRL:  reg_rdata <= ctrl_view;
          RA_PROG:  reg_rdata <= 32'(progress);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wbf_seq.sv
module wbf_seq #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    pitch,
  input  logic [DIM_W-1:0] height,
  input  logic             ien,
  input  logic             veof,
  input  logic             pwrdn,
  input  logic             start_cmd,
  input  logic             abort_cmd,
  input  logic             px_valid,
  input  logic [DW-1:0]    px_data,
  input  logic             px_eol,
  output logic             px_ready,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data,
  output logic [DW/8-1:0]  mem_strb,
  output logic             vstart,
  output logic             irq,
  output logic             busy,
  output logic [DIM_W-1:0] progress
);
  localparam int unsigned   BPW  = DW / 8;
  localparam logic [AW-1:0] STEP = AW'(BPW);

  logic [AW-1:0]    line_base_q;
  logic [AW-1:0]    word_off_q;
  logic [DIM_W:0]   next_lines;
  logic             accept;

  assign px_ready   = busy && !pwrdn;
  assign accept     = px_valid && px_ready && !abort_cmd;
  assign next_lines = {1'b0, progress} + 1'b1;
  assign mem_strb   = mem_req ? '1 : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      progress    <= '0;
      line_base_q <= '0;
      word_off_q  <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_data    <= '0;
      vstart      <= 1'b0;
      irq         <= 1'b0;
    end else begin
      mem_req <= accept;
      vstart  <= 1'b0;
      irq     <= ien && !busy;
      if (accept) begin
        mem_addr <= line_base_q + word_off_q;
        mem_data <= px_data;
      end
      if (abort_cmd) begin
        busy <= 1'b0;
      end else if (start_cmd && !busy && !pwrdn) begin
        busy        <= 1'b1;
        progress    <= '0;
        line_base_q <= base;
        word_off_q  <= '0;
        vstart      <= 1'b1;
      end else if (accept) begin
        if (px_eol) begin
          progress    <= next_lines[DIM_W-1:0];
          line_base_q <= line_base_q + pitch;
          word_off_q  <= '0;
          if (next_lines >= {1'b0, height}) begin
            busy   <= 1'b0;
            vstart <= veof;
          end
        end else begin
          word_off_q <= word_off_q + STEP;
        end
      end
    end
  end
endmodule

// File: rtl/wb_frame_writer.sv
module wb_frame_writer
  import wbf_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned DIM_W     = 16,
  parameter int unsigned MAX_LINES = 4088
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pitch_err,
  input  logic              px_valid,
  input  logic [DW-1:0]     px_data,
  input  logic              px_eol,
  output logic              px_ready,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic [DW/8-1:0]   mem_strb,
  output logic              vstart,
  output logic              irq
);
  logic [AW-1:0]    base_w;
  logic [AW-1:0]    pitch_w;
  logic [DIM_W-1:0] height_w;
  logic [DIM_W-1:0] prog_w;
  logic             ien_w;
  logic             veof_w;
  logic             pwrdn_w;
  logic             busy_w;
  logic             start_w;
  logic             abort_w;

  wbf_regs #(.AW(AW), .DIM_W(DIM_W), .MAX_LINES(MAX_LINES)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pitch_err(pitch_err), .busy(busy_w), .progress(prog_w),
    .base(base_w), .pitch(pitch_w), .height(height_w), .ien(ien_w),
    .veof(veof_w), .pwrdn(pwrdn_w), .start_cmd(start_w), .abort_cmd(abort_w)
  );

  wbf_seq #(.AW(AW), .DW(DW), .DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst(rst), .base(base_w), .pitch(pitch_w), .height(height_w),
    .ien(ien_w), .veof(veof_w), .pwrdn(pwrdn_w), .start_cmd(start_w),
    .abort_cmd(abort_w), .px_valid(px_valid), .px_data(px_data),
    .px_eol(px_eol), .px_ready(px_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_strb(mem_strb),
    .vstart(vstart), .irq(irq), .busy(busy_w), .progress(prog_w)
  );
endmodule

// File: rtl/wbf_checker.sv
module wbf_checker #(
  parameter int unsigned DIM_W     = 16,
  parameter int unsigned MAX_LINES = 4088
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             mem_req,
  input logic [3:0]       mem_strb,
  input logic             busy,
  input logic             pwrdn,
  input logic             irq,
  input logic [DIM_W-1:0] progress,
  input logic [DIM_W-1:0] height
);
  AST_FULL_STROBES: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_strb == 4'hf)); // R6
  AST_REQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(busy)); // R5
  AST_NO_REQ_PWRDN: assert property (@(posedge clk) disable iff (rst)
    $past(pwrdn) |-> !mem_req); // R10
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == 3'd3 && reg_wdata[14]) |-> !busy); // R9
  AST_PROG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (progress == '0)); // R7
  AST_HEIGHT_CAP: assert property (@(posedge clk) disable iff (rst)
    height <= DIM_W'(MAX_LINES)); // R3
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(busy)); // R8
endmodule

bind wb_frame_writer wbf_checker #(.DIM_W(DIM_W), .MAX_LINES(MAX_LINES)) i_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_strb(mem_strb),
  .busy(busy_w), .pwrdn(pwrdn_w), .irq(irq), .progress(prog_w),
  .height(height_w)
);

// File: tb/test_wb_frame_writer.sv
`timescale 1ns/1ps
module test_wb_frame_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pitch_err;
  logic        px_valid = 1'b0, px_eol = 1'b0;
  logic [31:0] px_data = '0;
  logic        px_ready, mem_req, vstart, irq;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_strb;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  wb_frame_writer i_wb_frame_writer (.*);

  localparam int NV = 4;
  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_8004, 32'h0000_0000, 32'h4000_0100};
  localparam logic [31:0] V_PITCH[NV] = '{32'h40, 32'h100, 32'h10, 32'h2000};
  localparam int          V_H    [NV] = '{3, 1, 4, 2};
  localparam int          V_WPL  [NV] = '{2, 3, 1, 4};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input logic e);
    @(negedge clk); px_valid = 1'b1; px_data = d; px_eol = e;
    @(posedge clk); @(negedge clk); px_valid = 1'b0; px_eol = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R5: watchdog actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // Reset state
    rd(3'd3, v); chk("R11 reset ctrl", v, 32'h5440_0000);
    rd(3'd4, v); chk("R7 reset progress", v, 32'h0);
    chk("R8 reset irq", {31'b0, irq}, 32'h0);
    chk("R6 reset mem_req", {31'b0, mem_req}, 32'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic veof_i;
      veof_i = i[0];
      wr(3'd0, V_BASE[i]);
      wr(3'd1, V_PITCH[i]);
      wr(3'd2, {16'(V_H[i]), 16'(V_WPL[i] * 4)});
      wr(3'd3, 32'h5 | (veof_i ? 32'h8000 : 32'h0));
      chk("R12 start pulse", {31'b0, vstart}, 32'h1);
      rd(3'd3, v);
      chk("R5 busy set", {31'b0, v[1]}, 32'h1);
      chk("R4 start reads 0", {31'b0, v[0]}, 32'h0);
      for (int l = 0; l < V_H[i]; l++) begin
        for (int w = 0; w < V_WPL[i]; w++) begin
          logic [31:0] d;
          d = {8'(i), 8'(l), 16'(w)} ^ 32'hA5A5_0000;
          push(d, w == V_WPL[i] - 1);
          chk("R6 req", {31'b0, mem_req}, 32'h1);
          chk("R6 addr", mem_addr, V_BASE[i] + 32'(l) * V_PITCH[i] + 32'(w * 4));
          chk("R6 data", mem_data, d);
          chk("R6 strb", {28'b0, mem_strb}, 32'hf);
        end
      end
      chk("R12 end pulse", {31'b0, vstart}, {31'b0, veof_i});
      rd(3'd4, v); chk("R7 progress", v, 32'(V_H[i]));
      rd(3'd3, v); chk("R5 busy cleared", {31'b0, v[1]}, 32'h0);
      chk("R8 irq idle", {31'b0, irq}, 32'h1);
    end

    // Interrupt acknowledge
    wr(3'd3, 32'h0);
    @(negedge clk);
    chk("R8 irq ack", {31'b0, irq}, 32'h0);

    // Base alignment
    wr(3'd0, 32'h0000_1003);
    rd(3'd0, v); chk("R1 base align", v, 32'h0000_1000);

    // Pitch validation
    wr(3'd1, 32'h40);
    chk("R2 good pitch err", {31'b0, pitch_err}, 32'h0);
    wr(3'd1, 32'h48);
    chk("R2 bad pitch err", {31'b0, pitch_err}, 32'h1);
    rd(3'd1, v); chk("R2 pitch kept", v, 32'h40);

    // Height clamp
    wr(3'd2, {16'd5000, 16'd7});
    rd(3'd2, v); chk("R3 size clamp", v, {16'd4088, 16'd7});

    // Power-down blocks start and stream
    wr(3'd3, 32'h0020_0001);
    rd(3'd3, v);
    chk("R10 pwrdn bit", {31'b0, v[21]}, 32'h1);
    chk("R4 start ignored pwrdn", {31'b0, v[1]}, 32'h0);
    chk("R10 ready low", {31'b0, px_ready}, 32'h0);
    push(32'h1234, 1'b1);
    chk("R10 no write", {31'b0, mem_req}, 32'h0);
    wr(3'd3, 32'h0);

    // Start while busy, then abort
    wr(3'd1, 32'h20);
    wr(3'd2, {16'd4, 16'd4});
    wr(3'd3, 32'h1);
    push(32'hCAFE, 1'b1);
    wr(3'd3, 32'h1);
    rd(3'd4, v); chk("R4 start ignored busy", v, 32'h1);
    wr(3'd3, 32'h4000);
    rd(3'd3, v);
    chk("R9 abort busy", {31'b0, v[1]}, 32'h0);
    chk("R9 abort reads 0", {31'b0, v[14]}, 32'h0);
    push(32'hBEEF, 1'b0);
    chk("R9 no write after abort", {31'b0, mem_req}, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule